// File: doc/BRIEF.md
# Watchdog Timer with Locked Source Selection

This block is a watchdog that asks the CPU for a non-maskable interrupt when software fails to restart it in time. A counter advances on the clock-enable pulses of one of two divided oscillator sources. If the counter wraps past its maximum, the block raises a request pulse on its NMI output. Software restarts the counter through a small register interface. It can also switch off the interrupt request without stopping the count, and it can change the count source, but only after setting an unlock bit.

The two source enables come from prescalers outside the block. When the selected source stops, for example while its oscillator is halted, its enable stays low. The counter then simply waits and keeps its value. A restart right before sleep and another right after wake-up keep a noisy start of the oscillator from causing a false interrupt.

Top module: `wdt_guard`

## Requirements
- R1: After reset the source select is 0 (slow source), the unlock bit is 0, the NMI enable is 1, the counter is 0 and `nmi_req` is low.
- R2: The source-select field is bit 4 at address 0. A write to it changes the selection only if the unlock bit (bit 0 at address 1) reads 1. Otherwise the stored selection is left unchanged.
- R3: With select 0 only `slow_tick` advances the counter. With select 1 only `fast_tick` advances it. The other enable has no effect.
- R4: On cycles where the selected enable is low, the counter keeps its value, so overflow comes after exactly 2^CNT_W selected enables, however they are spaced.
- R5: Writing 1 to bit 0 at address 0 clears the counter, and counting continues from the next enable. Writing 0 there leaves the count untouched.
- R6: Bit 0 at address 0 always reads 0.
- R7: When the counter wraps from all ones to zero with the NMI enable (bit 1 at address 1) at 1, `nmi_req` is high for exactly one clock cycle, in the cycle after the wrapping enable.
- R8: With the NMI enable at 0, a wrap gives no request, but the counter keeps counting through it.
- R9: A restart write in the same cycle as a wrapping enable wins: the counter clears and no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0: control, 1: protection/enable) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` (combinational) |
| slow_tick | input | 1 | Count enable from the slow oscillator divided by 16 |
| fast_tick | input | 1 | Count enable from the fast oscillator divided by 16 |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |

## Verification
The bound checker watches several rules on every cycle:
- a request lasts one cycle and always follows a wrap seen while the NMI enable was set;
- a restart clears the counter and never coincides with a wrap;
- the counter holds whenever its selected enable is absent;
- the source select never moves while the unlock bit is clear;
- the restart bit reads as 0.

Whether the right source feeds the counter can only be shown by the bench's scenarios, which measure the number of enables from restart to request. The same holds for a disabled request period that continues the count, and for the exact overflow distance after a partial count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PROT = 2'd1;

  localparam int KICK_BIT   = 0;
  localparam int SRC_BIT    = 4;
  localparam int UNLOCK_BIT = 0;
  localparam int NMIEN_BIT  = 1;

  typedef enum logic {
    SRC_SLOW = 1'b0,
    SRC_FAST = 1'b1
  } src_e;

  typedef struct packed {
    logic kick;
    logic src_wr;
    src_e src_val;
    logic prot_wr;
    logic unlock_val;
    logic nmien_val;
  } wr_dec_t;

  function automatic logic addr_hit(input logic wr, input logic [ADDR_W-1:0] addr,
                                    input logic [ADDR_W-1:0] target);
    return wr && (addr == target);
  endfunction

endpackage

// File: rtl/wdt_decode.sv
module wdt_decode
  import wdt_pkg::*;
(
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  src_e              src_q,
  input  logic              unlock_q,
  input  logic              nmien_q,
  output wr_dec_t           dec,
  output logic [DATA_W-1:0] cfg_rdata
);

  logic ctrl_hit;
  logic prot_hit;
  logic [DATA_W-1:0] unused_wdata;

  assign ctrl_hit = addr_hit(cfg_wr, cfg_addr, ADDR_CTRL);
  assign prot_hit = addr_hit(cfg_wr, cfg_addr, ADDR_PROT);
  assign unused_wdata = cfg_wdata;

  always_comb begin
    dec            = '0;
    dec.kick       = ctrl_hit && cfg_wdata[KICK_BIT];
    dec.src_wr     = ctrl_hit;
    dec.src_val    = src_e'(cfg_wdata[SRC_BIT]);
    dec.prot_wr    = prot_hit;
    dec.unlock_val = cfg_wdata[UNLOCK_BIT];
    dec.nmien_val  = cfg_wdata[NMIEN_BIT];
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_addr)
      ADDR_CTRL: cfg_rdata[SRC_BIT] = src_q;
      ADDR_PROT: begin
        cfg_rdata[UNLOCK_BIT] = unlock_q;
        cfg_rdata[NMIEN_BIT]  = nmien_q;
      end
      default:   cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
  import wdt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  wr_dec_t dec,
  output src_e    src_q,
  output logic    unlock_q,
  output logic    nmien_q,
  output logic    src_commit
);

  assign src_commit = dec.src_wr && unlock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= SRC_SLOW;
      unlock_q <= 1'b0;
      nmien_q  <= 1'b1;
    end else begin
      if (src_commit) src_q <= dec.src_val;
      if (dec.prot_wr) begin
        unlock_q <= dec.unlock_val;
        nmien_q  <= dec.nmien_val;
      end
    end
  end

endmodule

// File: rtl/wdt_src_mux.sv
module wdt_src_mux #(
  parameter int NUM_SRC = 2,
  localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] tick_vec,
  input  logic [SEL_W-1:0]   sel,
  output logic               tick_sel
);

  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = tick_vec[g] && (sel == SEL_W'(g));
  end

  assign tick_sel = |hit;

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             kick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_evt
);

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c,
                                            input logic t, input logic k);
    if (k)      return '0;
    else if (t) return c + 1'b1;
    else        return c;
  endfunction

  function automatic logic wraps(input logic [CNT_W-1:0] c,
                                 input logic t, input logic k);
    return t && !k && (c == {CNT_W{1'b1}});
  endfunction

  assign wrap_evt = wraps(cnt, tick, kick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= step(cnt, tick, kick);
  end

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              slow_tick,
  input  logic              fast_tick,
  output logic              nmi_req
);

  wr_dec_t          dec;
  src_e             src_q;
  logic             unlock_q;
  logic             nmien_q;
  logic             src_commit;
  logic             tick_sel;
  logic             wrap_evt;
  logic [CNT_W-1:0] cnt;
  logic             nmi_q;

  wdt_decode u_dec (
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .src_q     (src_q),
    .unlock_q  (unlock_q),
    .nmien_q   (nmien_q),
    .dec       (dec),
    .cfg_rdata (cfg_rdata)
  );

  wdt_cfg_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec        (dec),
    .src_q      (src_q),
    .unlock_q   (unlock_q),
    .nmien_q    (nmien_q),
    .src_commit (src_commit)
  );

  wdt_src_mux #(.NUM_SRC(2)) u_mux (
    .tick_vec ({fast_tick, slow_tick}),
    .sel      (src_q),
    .tick_sel (tick_sel)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_sel),
    .kick     (dec.kick),
    .cnt      (cnt),
    .wrap_evt (wrap_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_q <= 1'b0;
    else        nmi_q <= wrap_evt && nmien_q;
  end

  assign nmi_req = nmi_q;

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk
  import wdt_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              kick,
  input logic              wrap_evt,
  input logic              tick_sel,
  input logic [CNT_W-1:0]  cnt,
  input logic              nmi_req,
  input logic              nmien_q,
  input logic              unlock_q,
  input logic              src_q,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_rdata
);

  AST_NMI_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req); // R7

  AST_NMI_FROM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> ($past(wrap_evt) && $past(nmien_q))); // R8

  AST_LOCKED_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !unlock_q |=> $stable(src_q)); // R2

  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt == '0)); // R5

  AST_KICK_BEATS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> !wrap_evt); // R9

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_sel && !kick) |=> $stable(cnt)); // R4

  AST_KICK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == ADDR_CTRL) |-> !cfg_rdata[KICK_BIT]); // R6

endmodule

bind wdt_guard wdt_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .kick      (dec.kick),
  .wrap_evt  (wrap_evt),
  .tick_sel  (tick_sel),
  .cnt       (cnt),
  .nmi_req   (nmi_req),
  .nmien_q   (nmien_q),
  .unlock_q  (unlock_q),
  .src_q     (src_q),
  .cfg_addr  (cfg_addr),
  .cfg_rdata (cfg_rdata)
);

// File: tb/wdt_guard_bench.sv
`timescale 1ns/1ps
module wdt_guard_bench;

  localparam int CNT_W = 6;
  localparam int FULL  = 1 << CNT_W;
  localparam int NVEC  = 9;

  // {req id, addr, wdata, expected readback}
  localparam logic [21:0] VEC [NVEC] = '{
    {4'd1, 2'd1, 8'h02, 8'h02},
    {4'd2, 2'd0, 8'h10, 8'h00},
    {4'd2, 2'd1, 8'h03, 8'h03},
    {4'd6, 2'd0, 8'h11, 8'h10},
    {4'd2, 2'd0, 8'h00, 8'h00},
    {4'd2, 2'd1, 8'h02, 8'h02},
    {4'd2, 2'd0, 8'h10, 8'h00},
    {4'd8, 2'd1, 8'h00, 8'h00},
    {4'd8, 2'd1, 8'h02, 8'h02}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       slow_tick = 1'b0;
  logic       fast_tick = 1'b0;
  logic       nmi_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdt_guard #(.CNT_W(CNT_W)) u_wdt_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .slow_tick (slow_tick),
    .fast_tick (fast_tick),
    .nmi_req   (nmi_req)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  // Drives enables for up to 'limit' cycles; returns the number of enables
  // given when nmi_req was seen, or -1 if none appeared.
  task automatic drive(input bit use_fast, input int limit, input bit sparse,
                       output int hit);
    int given = 0;
    hit = -1;
    for (int c = 0; c < limit; c++) begin
      @(negedge clk);
      if (nmi_req) begin
        hit = given;
        break;
      end
      if (!sparse || (c % 3 == 0)) begin
        slow_tick = !use_fast; fast_tick = use_fast; given++;
      end else begin
        slow_tick = 1'b0; fast_tick = 1'b0;
      end
    end
    if (hit < 0) begin
      @(negedge clk);
      if (nmi_req) hit = given;
    end
    slow_tick = 1'b0; fast_tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int hit;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check(d, 8'h00, "R1 ctrl reset");
    rd(2'd1, d); check(d, 8'h02, "R1 prot reset");
    check(nmi_req, 0, "R1 nmi reset");

    // Register vector walk: R2 lock, R6 kick reads 0, R8 enable bit
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][17:16], VEC[i][15:8]);
      rd(VEC[i][17:16], d);
      check(d, VEC[i][7:0], $sformatf("R%0d vector %0d", VEC[i][21:18], i));
    end

    // R7 overflow distance and pulse width
    wr(2'd0, 8'h01);
    drive(1'b0, 200, 1'b0, hit); check(hit, FULL, "R7 overflow distance");
    @(negedge clk); check(nmi_req, 0, "R7 single cycle pulse");

    // R4 sparse enables
    wr(2'd0, 8'h01);
    drive(1'b0, 400, 1'b1, hit); check(hit, FULL, "R4 sparse hold");

    // R3 source selection
    wr(2'd0, 8'h01);
    drive(1'b1, 150, 1'b0, hit); check(hit, -1, "R3 fast ignored on slow");
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h11);
    drive(1'b0, 150, 1'b0, hit); check(hit, -1, "R3 slow ignored on fast");
    drive(1'b1, 200, 1'b0, hit); check(hit, FULL, "R3 fast source counts");
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h02);

    // R5 kick with 0 does nothing, kick with 1 clears
    wr(2'd0, 8'h01);
    drive(1'b0, 30, 1'b0, hit); check(hit, -1, "R5 partial count");
    wr(2'd0, 8'h00);
    drive(1'b0, 200, 1'b0, hit); check(hit, FULL - 30, "R5 zero write no restart");
    wr(2'd0, 8'h01);
    drive(1'b0, 30, 1'b0, hit);
    wr(2'd0, 8'h01);
    drive(1'b0, 200, 1'b0, hit); check(hit, FULL, "R5 restart clears");

    // R8 disabled request, counting continues across wrap
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h01);
    drive(1'b0, 100, 1'b0, hit); check(hit, -1, "R8 suppressed");
    wr(2'd1, 8'h02);
    drive(1'b0, 200, 1'b0, hit); check(hit, 2 * FULL - 100, "R8 count continued");

    // R9 restart coinciding with wrapping enable
    wr(2'd0, 8'h01);
    drive(1'b0, FULL - 1, 1'b0, hit); check(hit, -1, "R9 prefill");
    @(negedge clk);
    slow_tick = 1'b1; cfg_wr = 1'b1; cfg_addr = 2'd0; cfg_wdata = 8'h01;
    @(negedge clk);
    slow_tick = 1'b0; cfg_wr = 1'b0;
    check(nmi_req, 0, "R9 no request on kick");
    drive(1'b0, 200, 1'b0, hit); check(hit, FULL, "R9 counter cleared");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule